// File: doc/BRIEF.md
# SCSI Controller Status and Interrupt Latch

This block keeps the three read-only bytes that a host CPU polls on a SCSI protocol controller: a status byte, an interrupt-cause byte and a sequence-step byte. It also drives the interrupt line to the processor. Other logic in the controller sends it one-cycle event pulses. Some are error and transfer conditions: gross error, parity error, terminal count and valid group code. The others are interrupt causes: an external bus reset, a bus reset issued by command, an illegal command, a disconnect or timeout, a service request, function complete, reselected, selected with ATN and selected without ATN. The live bus phase lines are fed in as well. Producing those events is not part of this block.

Each condition is held in its byte until the host reads the interrupt-cause register. The read strobe clears every held bit in the interrupt byte and in the upper five status bits at once. The three phase bits of the status byte are not held: they show the bus lines one cycle late. An event that arrives in the same cycle as the clearing read is kept, so it raises a fresh interrupt rather than being lost. The sequence-step byte is loaded by the sequencer. It reports how far a selection or target sequence got, and the value 4 marks a sequence that completed fully.

Top module: `scsi_stat_intr_latch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `status_o`, `intr_o`, `step_o`, `irq_o`, `seq_done_o` and `phase_bad_o` are all zero.
- R2: A pulse on `ev_stat_i` sets a status bit one clock later, and the bit stays set until the interrupt byte is read. The mapping is bit 3 to 0x40 (gross error), bit 2 to 0x20 (parity error), bit 1 to 0x10 (terminal count) and bit 0 to 0x08 (valid group code).
- R3: `status_o[2:0]` equals `phase_i` = {MSG, C/D, I/O} as sampled one clock earlier. A read of the interrupt byte does not clear these bits.
- R4: A pulse on `ev_intr_i[k]` sets `intr_o[k]` one clock later, for k from 0 to 6. The bit positions are 0x40 illegal command, 0x20 disconnect/timeout, 0x10 service request, 0x08 function complete, 0x04 reselected, 0x02 selected with ATN and 0x01 selected without ATN. Successive events OR together.
- R5: `status_o[7]` (interrupt pending) is 1 exactly when `intr_o` is nonzero. This holds whatever the value of `irq_en_i`.
- R6: `irq_o` is 1 exactly when `intr_o` is nonzero and `irq_en_i` was high one clock earlier.
- R7: If `rd_intr_i` is high in a cycle, the next cycle shows `intr_o` and `status_o[7:3]` holding only the events presented in that same cycle.
- R8: `soft_rst_i` clears `intr_o`, `status_o[7:3]` and `step_o` on the next clock. Events presented in the same cycle are dropped.
- R9: An external bus reset (`ev_busrst_ext_i`) always sets `intr_o[7]` (0x80). A bus reset issued by command (`ev_busrst_cmd_i`) sets it only when `cfg_mute_cmd_rst_i` is 0.
- R10: `step_wr_i` loads `step_val_i` into `step_o[2:0]`, and `step_o[7:3]` stays 0. The value is held across reads of the interrupt byte. `seq_done_o` is 1 exactly when `step_o` equals 4.
- R11: `phase_bad_o` is 1 exactly when the registered phase code `status_o[2:0]` is 4 or 5, the two codes that cannot occur on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst_i | input | 1 | Software reset pulse |
| rd_intr_i | input | 1 | Read strobe for the interrupt byte; clears the held state |
| irq_en_i | input | 1 | Interrupt output enable |
| cfg_mute_cmd_rst_i | input | 1 | Suppress the interrupt from a command-issued bus reset |
| ev_stat_i | input | 4 | Status events {gross, parity, terminal count, valid group} |
| ev_busrst_ext_i | input | 1 | Bus reset seen on the bus |
| ev_busrst_cmd_i | input | 1 | Bus reset caused by a software command |
| ev_intr_i | input | 7 | Interrupt-cause events for bits 6..0 |
| phase_i | input | 3 | Live {MSG, C/D, I/O} lines |
| step_wr_i | input | 1 | Load strobe for the sequence step |
| step_val_i | input | 3 | Sequence step value |
| status_o | output | 8 | Status byte |
| intr_o | output | 8 | Interrupt-cause byte |
| step_o | output | 8 | Sequence-step byte |
| irq_o | output | 1 | Interrupt request to the CPU |
| seq_done_o | output | 1 | Sequence step equals 4 |
| phase_bad_o | output | 1 | Registered phase code is 4 or 5 |

## Verification
The assertions check relationships that must hold on every cycle:
- the pending bit tracks a nonzero interrupt byte, and `irq_o` never rises without that bit;
- a status event is always latched on the next clock;
- the phase bits follow the bus lines one clock late;
- a plain read with no new events empties the interrupt byte;
- the step byte holds still when it is not written;
- the illegal-phase flag agrees with the phase bits.

Other behaviours need the bench's scenarios. These are the exact mapping of each bit under a sweep of every event pattern, the collision of a read with a new event, the dropping of events during a software reset, and the muting of a command-issued bus reset.

// File: rtl/scsi_sil_pkg.sv
package scsi_sil_pkg;
  localparam int REG_W      = 8;
  localparam int STAT_EV_W  = 4;
  localparam int INTR_EV_W  = 7;
  localparam int PHASE_W    = 3;
  localparam int STEP_W     = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_DATA_OUT = 3'd0,
    PH_DATA_IN  = 3'd1,
    PH_COMMAND  = 3'd2,
    PH_STATUS   = 3'd3,
    PH_BAD4     = 3'd4,
    PH_BAD5     = 3'd5,
    PH_MSG_OUT  = 3'd6,
    PH_MSG_IN   = 3'd7
  } bus_phase_e;

  localparam logic [STEP_W-1:0] STEP_COMPLETE = 3'd4;
endpackage

// File: rtl/sil_sticky.sv
module sil_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  // a clear and a new event in the same cycle: the new event survives
  always_comb nxt = (clr ? '0 : q) | set;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/sil_phase_sync.sv
module sil_phase_sync
  import scsi_sil_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [PHASE_W-1:0] phase_q,
  output logic               bad_q
);
  bus_phase_e ph;
  assign ph = bus_phase_e'(phase_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      phase_q <= phase_i;
      bad_q   <= (ph == PH_BAD4) || (ph == PH_BAD5);
    end
  end
endmodule

// File: rtl/scsi_stat_intr_latch.sv
module scsi_stat_intr_latch
  import scsi_sil_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 soft_rst_i,
  input  logic                 rd_intr_i,
  input  logic                 irq_en_i,
  input  logic                 cfg_mute_cmd_rst_i,
  input  logic [STAT_EV_W-1:0] ev_stat_i,
  input  logic                 ev_busrst_ext_i,
  input  logic                 ev_busrst_cmd_i,
  input  logic [INTR_EV_W-1:0] ev_intr_i,
  input  logic [PHASE_W-1:0]   phase_i,
  input  logic                 step_wr_i,
  input  logic [STEP_W-1:0]    step_val_i,
  output logic [REG_W-1:0]     status_o,
  output logic [REG_W-1:0]     intr_o,
  output logic [REG_W-1:0]     step_o,
  output logic                 irq_o,
  output logic                 seq_done_o,
  output logic                 phase_bad_o
);
  localparam int INTR_W = INTR_EV_W + 1;

  logic                 clr;
  logic [INTR_W-1:0]    intr_set, intr_nxt, intr_q;
  logic [STAT_EV_W-1:0] stat_set, stat_nxt, stat_q;
  logic [PHASE_W-1:0]   phase_q;
  logic                 bad_q;
  logic                 pend_q, irq_q;
  logic [STEP_W-1:0]    step_q;
  logic                 done_q;
  logic                 busrst_any;

  assign clr        = rd_intr_i | soft_rst_i;
  assign busrst_any = ev_busrst_ext_i | (ev_busrst_cmd_i & ~cfg_mute_cmd_rst_i);
  assign intr_set   = soft_rst_i ? '0 : {busrst_any, ev_intr_i};
  assign stat_set   = soft_rst_i ? '0 : ev_stat_i;

  sil_sticky #(.W(INTR_W)) u_intr (
    .clk(clk), .rst(rst), .clr(clr), .set(intr_set), .nxt(intr_nxt), .q(intr_q)
  );

  sil_sticky #(.W(STAT_EV_W)) u_stat (
    .clk(clk), .rst(rst), .clr(clr), .set(stat_set), .nxt(stat_nxt), .q(stat_q)
  );

  sil_phase_sync u_phase (
    .clk(clk), .rst(rst), .phase_i(phase_i), .phase_q(phase_q), .bad_q(bad_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= |intr_nxt;
      irq_q  <= (|intr_nxt) & irq_en_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst_i) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else if (step_wr_i) begin
      step_q <= step_val_i;
      done_q <= (step_val_i == STEP_COMPLETE);
    end
  end

  assign status_o    = {pend_q, stat_q, phase_q};
  assign intr_o      = intr_q;
  assign step_o      = {{(REG_W-STEP_W){1'b0}}, step_q};
  assign irq_o       = irq_q;
  assign seq_done_o  = done_q;
  assign phase_bad_o = bad_q;
endmodule

// File: rtl/sil_checker.sv
module sil_checker
  import scsi_sil_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 soft_rst_i,
  input logic                 rd_intr_i,
  input logic [STAT_EV_W-1:0] ev_stat_i,
  input logic                 ev_busrst_ext_i,
  input logic                 ev_busrst_cmd_i,
  input logic [INTR_EV_W-1:0] ev_intr_i,
  input logic [PHASE_W-1:0]   phase_i,
  input logic                 step_wr_i,
  input logic [REG_W-1:0]     status_o,
  input logic [REG_W-1:0]     intr_o,
  input logic [REG_W-1:0]     step_o,
  input logic                 irq_o,
  input logic                 phase_bad_o
);
  assert_pending_R5: assert property (@(posedge clk) disable iff (rst)
    status_o[7] == (intr_o != '0));

  assert_irq_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> status_o[7]);

  assert_gross_latched_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_stat_i[3] && !soft_rst_i) |=> status_o[6]);

  assert_phase_live_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o[2:0] == $past(phase_i)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_intr_i && ev_intr_i == '0 && !ev_busrst_ext_i && !ev_busrst_cmd_i)
      |=> (intr_o == '0));

  assert_step_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!step_wr_i && !soft_rst_i) |=> $stable(step_o));

  assert_phase_bad_R11: assert property (@(posedge clk) disable iff (rst)
    phase_bad_o == (status_o[2:1] == 2'b10));
endmodule

bind scsi_stat_intr_latch sil_checker u_chk (
  .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .rd_intr_i(rd_intr_i),
  .ev_stat_i(ev_stat_i), .ev_busrst_ext_i(ev_busrst_ext_i),
  .ev_busrst_cmd_i(ev_busrst_cmd_i), .ev_intr_i(ev_intr_i), .phase_i(phase_i),
  .step_wr_i(step_wr_i), .status_o(status_o), .intr_o(intr_o), .step_o(step_o),
  .irq_o(irq_o), .phase_bad_o(phase_bad_o)
);

// File: tb/scsi_stat_intr_latch_tb.sv
module scsi_stat_intr_latch_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst_i = 0, rd_intr_i = 0, irq_en_i = 0, cfg_mute_cmd_rst_i = 0;
  logic [3:0] ev_stat_i = 0;
  logic       ev_busrst_ext_i = 0, ev_busrst_cmd_i = 0;
  logic [6:0] ev_intr_i = 0;
  logic [2:0] phase_i = 0;
  logic       step_wr_i = 0;
  logic [2:0] step_val_i = 0;
  logic [7:0] status_o, intr_o, step_o;
  logic       irq_o, seq_done_o, phase_bad_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scsi_stat_intr_latch u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic quiet();
    ev_stat_i = 0; ev_intr_i = 0; ev_busrst_ext_i = 0; ev_busrst_cmd_i = 0;
    rd_intr_i = 0; soft_rst_i = 0; step_wr_i = 0;
  endtask

  task automatic do_read();
    rd_intr_i = 1; tick(); rd_intr_i = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1: outputs zero while in reset
    chk({status_o, intr_o, step_o, irq_o, seq_done_o, phase_bad_o} == 0, "R1 in reset",
        {status_o, intr_o}, 0);
    rst = 0; tick();
    chk({status_o, intr_o, step_o, irq_o, seq_done_o, phase_bad_o} == 0, "R1 after reset",
        {status_o, intr_o}, 0);

    // R4 R9 R5 R6 R7: sweep all interrupt patterns, both enable values
    for (int en = 0; en < 2; en++) begin
      irq_en_i = en[0];
      for (int p = 0; p < 256; p++) begin
        ev_intr_i = p[6:0]; ev_busrst_ext_i = p[7]; tick(); quiet();
        chk(intr_o == p[7:0], "R4 intr latch", intr_o, p);
        chk(status_o[7] == (p != 0), "R5 pending", status_o[7], p != 0);
        chk(irq_o == ((p != 0) && en == 1), "R6 irq gate", irq_o, (p != 0) && en == 1);
        tick();
        chk(intr_o == p[7:0], "R4 hold", intr_o, p);
        do_read();
        chk(intr_o == 0 && status_o[7] == 0 && irq_o == 0, "R7 read clears", intr_o, 0);
      end
    end

    // R4: OR accumulation
    irq_en_i = 1;
    ev_intr_i = 7'h01; tick(); ev_intr_i = 7'h08; tick(); quiet();
    chk(intr_o == 8'h09, "R4 accumulate", intr_o, 8'h09);
    // R7: read with a colliding event keeps the event
    rd_intr_i = 1; ev_intr_i = 7'h10; tick(); quiet();
    chk(intr_o == 8'h10, "R7 collision kept", intr_o, 8'h10);
    chk(irq_o == 1, "R7 new irq", irq_o, 1);
    do_read();

    // R2: sweep status events
    phase_i = 0;
    for (int s = 0; s < 16; s++) begin
      ev_stat_i = s[3:0]; tick(); quiet(); tick();
      chk(status_o == {1'b0, s[3:0], 3'b000}, "R2 status latch", status_o, s << 3);
      do_read();
      chk(status_o == 8'h00, "R2 cleared by read", status_o, 0);
    end
    ev_stat_i = 4'b1000; tick(); quiet();
    rd_intr_i = 1; ev_stat_i = 4'b0100; tick(); quiet();
    chk(status_o == 8'h20, "R7 status collision", status_o, 8'h20);
    do_read();

    // R3 R11: phase sweep; read leaves phase bits
    for (int ph = 0; ph < 8; ph++) begin
      phase_i = ph[2:0]; ev_stat_i = 4'b0001; tick(); quiet();
      chk(status_o[2:0] == ph[2:0], "R3 phase live", status_o[2:0], ph);
      chk(phase_bad_o == (ph == 4 || ph == 5), "R11 bad phase", phase_bad_o, ph == 4 || ph == 5);
      do_read();
      chk(status_o == {5'b0, ph[2:0]}, "R3 phase survives read", status_o, ph);
    end
    phase_i = 0; tick();

    // R9: command-issued bus reset muting
    cfg_mute_cmd_rst_i = 1; ev_busrst_cmd_i = 1; tick(); quiet();
    chk(intr_o == 0 && irq_o == 0, "R9 muted cmd reset", intr_o, 0);
    ev_busrst_ext_i = 1; tick(); quiet();
    chk(intr_o == 8'h80, "R9 external reset not muted", intr_o, 8'h80);
    do_read();
    cfg_mute_cmd_rst_i = 0; ev_busrst_cmd_i = 1; tick(); quiet();
    chk(intr_o == 8'h80, "R9 cmd reset unmuted", intr_o, 8'h80);
    do_read();

    // R10: step loads, done flag, survives read
    for (int v = 0; v < 8; v++) begin
      step_val_i = v[2:0]; step_wr_i = 1; tick(); quiet();
      chk(step_o == v, "R10 step load", step_o, v);
      chk(seq_done_o == (v == 4), "R10 done flag", seq_done_o, v == 4);
      do_read();
      chk(step_o == v, "R10 step survives read", step_o, v);
    end

    // R8: soft reset clears and drops coinciding events
    step_val_i = 4; step_wr_i = 1; ev_intr_i = 7'h04; ev_stat_i = 4'b0010; tick(); quiet();
    soft_rst_i = 1; ev_intr_i = 7'h02; ev_stat_i = 4'b0100; tick(); quiet();
    chk(intr_o == 0 && status_o[7:3] == 0, "R8 soft clears latches", {intr_o, status_o}, 0);
    chk(step_o == 0 && seq_done_o == 0 && irq_o == 0, "R8 soft clears step", step_o, 0);

    // R6: enable low keeps line low but pending visible
    irq_en_i = 0; ev_intr_i = 7'h20; tick(); quiet();
    chk(irq_o == 0 && status_o[7] == 1, "R6 disabled still pending", {irq_o, status_o[7]}, 1);
    irq_en_i = 1; tick();
    chk(irq_o == 1, "R6 enable later", irq_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule